// File: doc/BRIEF.md
# One-Wire Bus Master

This block is a bus master for single-wire serial buses with open-drain signalling. It serves up to sixteen separate lines. Software works with two word registers. A control/status word at byte offset 0x0 starts an operation. A divider word at byte offset 0x4 sets the length of the time base. One write with the cycle bit set runs exactly one operation on the selected port. The operation is either a reset pulse followed by a presence sample, or a single bit slot. Software then polls the busy bit until it drops and reads the sampled bit back from the data position.

All timing is counted in ticks. One tick lasts (divider + 1) system clocks. The normal-speed divider is meant to give a 5 µs tick and the overdrive divider a 1 µs tick. The overdrive bit in the start write picks which divider and which set of slot lengths the operation uses. A normal bit slot is 14 ticks long. The line is held low for 1 tick when sending a one, or 12 ticks when sending a zero, and it is sampled when tick 3 ends. A normal reset holds the line low for 96 ticks, samples at tick 110 and ends at tick 192. In overdrive the slot is 10 ticks (low 1 or 8 ticks, sample at tick 2) and the reset is 96 ticks (low 48 ticks, sample at tick 56).

Top module: `onewire_master`

## Requirements
- R1: After reset no port is driven, `irq` is low, and both registers read 0.
- R2: The divider word holds the normal divider in bits 15:0 and the overdrive divider in bits 31:16, and reads back as written. One tick lasts (divider + 1) clocks.
- R3: A normal-speed bit slot drives the line low for 1 tick when control bit 0 (data) is 1, or for 12 ticks when it is 0. The slot lasts 14 ticks in total.
- R4: A write with bit 3 (cycle) set starts an operation when the block is idle. Bit 3 then reads 1 until the operation ends and reads 0 afterwards.
- R5: With bit 1 (reset) set, the operation is a reset. In normal speed the line is held low for 96 ticks, the presence sample is taken at tick 110, and the operation ends at tick 192. The data bit then reads 0 if a device held the line low, and 1 if no device did.
- R6: After a bit slot, the data bit holds the sampled line level. A write-1 slot therefore reads 0 if a device holds the line low, and 1 if the line is free. A write-0 slot reads back 0.
- R7: With bit 2 (overdrive) set, ticks use the overdrive divider. A slot drives low for 1 or 8 ticks over 10 ticks in total. A reset drives low for 48 ticks over 96 ticks in total.
- R8: Only the port chosen by bits 11:8 is ever driven. All other ports stay released.
- R9: When an operation ends, the interrupt flag (bit 6) is set. `irq` is high while both bit 6 and bit 7 (interrupt enable) are set. A read of the control word clears bit 6.
- R10: Writes to the control word while an operation runs are ignored. The port, mode and timing of the running operation do not change.
- R11: Bit 4 (power) is stored and reads back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Byte offset; bit 2 selects the divider word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word |
| irq | output | 1 | Interrupt request |
| pad_in | input | PORTS | Line levels as seen at the pins |
| pad_oe | output | PORTS | 1 = pull that line low |

## Verification
The checks assume that both dividers are at least 2. With a smaller divider, the two-flop synchronizer delay would reach the sample point after a one-tick low pulse. The stimulus uses 3 for the normal divider and 2 for the overdrive divider. The checks also assume that a responding device holds the line at a steady level for the whole operation. The bench models this with a per-port pull-down that is set before the start write and removed after completion. Register accesses are single-cycle strobes driven between clock edges.

// File: rtl/onewire_master.sv
module onewire_master #(
  parameter int PORTS       = 16,
  parameter int DIV_W       = 16,
  parameter int N_SLOT_LOW0 = 12,
  parameter int N_SLOT_SMP  = 3,
  parameter int N_SLOT_END  = 14,
  parameter int N_RST_LOW   = 96,
  parameter int N_RST_SMP   = 110,
  parameter int N_RST_END   = 192,
  parameter int O_SLOT_LOW0 = 8,
  parameter int O_SLOT_SMP  = 2,
  parameter int O_SLOT_END  = 10,
  parameter int O_RST_LOW   = 48,
  parameter int O_RST_SMP   = 56,
  parameter int O_RST_END   = 96
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_we,
  input  logic [2:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic             irq,
  input  logic [PORTS-1:0] pad_in,
  output logic [PORTS-1:0] pad_oe
);
  localparam int SEL_W = (PORTS > 1) ? $clog2(PORTS) : 1;
  localparam int T_MAX = (N_RST_END > O_RST_END) ? N_RST_END : O_RST_END;
  localparam int T_W   = $clog2(T_MAX + 1);

  logic [DIV_W-1:0] div_n, div_o, pc;
  logic [T_W-1:0]   t, t_nx, low_len, smp_at, end_at;
  logic [3:0]       port;
  logic             dat, rst_m, ovd, pwr, ien, iflag, busy, txb, line;
  logic [PORTS-1:0] sync1, sync2;
  logic [31:0]      csr_q;

  wire csr_wr = bus_sel &  bus_we & ~bus_addr[2];
  wire div_wr = bus_sel &  bus_we &  bus_addr[2];
  wire csr_rd = bus_sel & ~bus_we & ~bus_addr[2];
  wire tick   = busy && (pc == '0);

  assign t_nx = t + 1'b1;

  always_comb begin
    if (ovd) begin
      low_len = rst_m ? T_W'(O_RST_LOW) : (txb ? T_W'(1) : T_W'(O_SLOT_LOW0));
      smp_at  = rst_m ? T_W'(O_RST_SMP) : T_W'(O_SLOT_SMP);
      end_at  = rst_m ? T_W'(O_RST_END) : T_W'(O_SLOT_END);
    end else begin
      low_len = rst_m ? T_W'(N_RST_LOW) : (txb ? T_W'(1) : T_W'(N_SLOT_LOW0));
      smp_at  = rst_m ? T_W'(N_RST_SMP) : T_W'(N_SLOT_SMP);
      end_at  = rst_m ? T_W'(N_RST_END) : T_W'(N_SLOT_END);
    end
  end

  always_comb begin
    line = 1'b1;
    if (int'(port) < PORTS) line = sync2[port[SEL_W-1:0]];
  end

  genvar i;
  generate
    for (i = 0; i < PORTS; i++) begin : g_pad
      assign pad_oe[i] = busy && (port == 4'(i)) && (t < low_len);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1 <= '1;
      sync2 <= '1;
    end else begin
      sync1 <= pad_in;
      sync2 <= sync1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_n <= '0; div_o <= '0; pc <= '0; t <= '0; port <= '0;
      dat <= 1'b0; rst_m <= 1'b0; ovd <= 1'b0; pwr <= 1'b0;
      ien <= 1'b0; iflag <= 1'b0; busy <= 1'b0; txb <= 1'b0;
    end else begin
      if (div_wr) begin
        div_n <= bus_wdata[DIV_W-1:0];
        div_o <= bus_wdata[16 +: DIV_W];
      end
      if (csr_rd) iflag <= 1'b0;
      if (csr_wr && !busy) begin
        dat   <= bus_wdata[0];
        rst_m <= bus_wdata[1];
        ovd   <= bus_wdata[2];
        pwr   <= bus_wdata[4];
        ien   <= bus_wdata[7];
        port  <= bus_wdata[11:8];
        if (bus_wdata[3]) begin
          busy <= 1'b1;
          txb  <= bus_wdata[0];
          t    <= '0;
          pc   <= bus_wdata[2] ? div_o : div_n;
        end
      end
      if (busy) begin
        if (tick) begin
          pc <= ovd ? div_o : div_n;
          t  <= t_nx;
          if (t_nx == smp_at) dat <= line;
          if (t_nx == end_at) begin
            busy  <= 1'b0;
            iflag <= 1'b1;
          end
        end else begin
          pc <= pc - 1'b1;
        end
      end
    end
  end

  assign csr_q     = {20'd0, port, ien, iflag, 1'b0, pwr, busy, ovd, rst_m, dat};
  assign bus_rdata = bus_addr[2] ? ((32'(div_o) << 16) | 32'(div_n)) : csr_q;
  assign irq       = iflag & ien;
endmodule

// File: rtl/onewire_master_chk.sv
module onewire_master_chk #(
  parameter int PORTS = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [PORTS-1:0] pad_oe,
  input logic             busy,
  input logic             iflag,
  input logic [3:0]       port
);
  a_r8_one_port: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pad_oe));

  a_r4_drive_only_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (|pad_oe) |-> busy);

  a_r9_flag_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> iflag);

  a_r10_port_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(port));

  a_r3_released_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (pad_oe == '0));
endmodule

bind onewire_master onewire_master_chk #(.PORTS(PORTS)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .pad_oe (pad_oe),
  .busy   (busy),
  .iflag  (iflag),
  .port   (port)
);

// File: tb/sim_onewire_master.sv
module sim_onewire_master;
  localparam int PORTS = 16;
  localparam int NDIV  = 3;
  localparam int ODIV  = 2;
  localparam int NT    = NDIV + 1;
  localparam int OT    = ODIV + 1;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, bus_sel = 1'b0, bus_we = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic irq;
  logic [PORTS-1:0] pad_oe;
  logic [PORTS-1:0] force_low = '0;
  logic [PORTS-1:0] pad_in;
  assign pad_in = ~pad_oe & ~force_low;

  onewire_master #(.PORTS(PORTS)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .pad_in(pad_in), .pad_oe(pad_oe));

  int checks = 0, fails = 0;
  int exp_w_q[$];
  string exp_tag_q[$];
  int exp_port = 0;
  int run_cnt = 0;
  bit bad_sel = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // monitor: measures every low pulse and pops the expected width
  always @(negedge clk) begin
    if (rst_n) begin
      if (pad_oe != '0) begin
        run_cnt++;
        if (pad_oe != (PORTS'(1) << exp_port)) bad_sel = 1'b1;
      end else if (run_cnt > 0) begin
        if (exp_w_q.size() == 0) chk("R8 unexpected pulse", run_cnt, 0);
        else begin
          chk(exp_tag_q.pop_front(), run_cnt, exp_w_q.pop_front());
          chk("R8 only selected port driven", int'(bad_sel), 0);
        end
        run_cnt = 0;
        bad_sel = 1'b0;
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic run(string tag, int port, bit rst, bit ovd, bit dat, bit frc,
                     int exp_w, int exp_busy, int exp_dat);
    logic [31:0] d;
    int n;
    exp_w_q.push_back(exp_w);
    exp_tag_q.push_back({tag, " low width"});
    exp_port = port;
    force_low[port] = frc;
    wr(3'h0, {20'd0, 4'(port), 4'b0000, 1'b1, ovd, rst, dat});
    n = 0;
    do begin
      rd(3'h0, d);
      if (d[3]) n++;
    end while (d[3]);
    chk({tag, " busy length"}, n, exp_busy);
    chk({tag, " data bit"}, int'(d[0]), exp_dat);
    force_low[port] = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int n;
    repeat (3) @(negedge clk);
    chk("R1 pad_oe after reset", int'(pad_oe), 0);
    chk("R1 irq after reset", int'(irq), 0);
    rst_n = 1'b1;
    @(negedge clk);
    rd(3'h0, d); chk("R1 control word after reset", int'(d), 0);
    rd(3'h4, d); chk("R1 divider word after reset", int'(d), 0);

    wr(3'h4, {16'(ODIV), 16'(NDIV)});
    rd(3'h4, d); chk("R2 divider readback", int'(d), (ODIV << 16) | NDIV);

    run("R3 normal write0 p0", 0, 0, 0, 0, 0, 12*NT, 14*NT, 0);
    run("R3 normal write1 p5", 5, 0, 0, 1, 0, 1*NT, 14*NT, 1);
    run("R6 read slot held low p5", 5, 0, 0, 1, 1, 1*NT, 14*NT, 0);
    run("R6 read slot free p15", 15, 0, 0, 1, 0, 1*NT, 14*NT, 1);
    run("R5 reset with presence p1", 1, 1, 0, 0, 1, 96*NT, 192*NT, 0);
    run("R5 reset no presence p9", 9, 1, 0, 0, 0, 96*NT, 192*NT, 1);
    run("R7 overdrive write0 p4", 4, 0, 1, 0, 0, 8*OT, 10*OT, 0);
    run("R7 overdrive read p4", 4, 0, 1, 1, 0, 1*OT, 10*OT, 1);
    run("R7 overdrive read low p6", 6, 0, 1, 1, 1, 1*OT, 10*OT, 0);
    run("R7 overdrive reset presence p12", 12, 1, 1, 0, 1, 48*OT, 96*OT, 0);

    // R9: interrupt with enable set, no polling during the cycle
    exp_w_q.push_back(12*NT); exp_tag_q.push_back("R9 slot low width"); exp_port = 3;
    wr(3'h0, {20'd0, 4'd3, 8'b1000_1000});
    repeat (14*NT + 2) @(negedge clk);
    chk("R9 irq raised at completion", int'(irq), 1);
    rd(3'h0, d);
    chk("R9 flag bit 6 set", int'(d[6]), 1);
    chk("R9 enable bit 7 reads back", int'(d[7]), 1);
    chk("R4 busy clear at completion", int'(d[3]), 0);
    chk("R9 irq drops after control read", int'(irq), 0);
    rd(3'h0, d);
    chk("R9 flag cleared by read", int'(d[6]), 0);

    // R9: enable clear keeps irq low while the flag is set; R11 power bit
    exp_w_q.push_back(1*NT); exp_tag_q.push_back("R9 masked slot low width"); exp_port = 7;
    wr(3'h0, {20'd0, 4'd7, 8'b0001_1001});
    repeat (14*NT + 2) @(negedge clk);
    chk("R9 irq masked", int'(irq), 0);
    rd(3'h0, d);
    chk("R9 flag set while masked", int'(d[6]), 1);
    chk("R11 power bit readback", int'(d[4]), 1);

    // R10: second write during a cycle is ignored
    exp_w_q.push_back(12*NT); exp_tag_q.push_back("R10 original slot low width"); exp_port = 2;
    wr(3'h0, {20'd0, 4'd2, 8'b0000_1000});
    wr(3'h0, {20'd0, 4'd7, 8'b0000_1011});
    n = 0;
    do begin
      rd(3'h0, d);
      if (d[3]) n++;
    end while (d[3]);
    chk("R10 busy length unchanged", n, 14*NT - 1);
    chk("R10 port field kept", int'(d[11:8]), 2);
    chk("R10 reset bit kept", int'(d[1]), 0);
    chk("R10 data of original slot", int'(d[0]), 0);

    repeat (4) @(negedge clk);
    chk("R8 all ports released when idle", int'(pad_oe), 0);
    chk("R3 all expected pulses seen", exp_w_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule